// File: doc/BRIEF.md
# HDLC Receive Flag-Stripping Deframer

The block takes a raw, bit-stuffed HDLC receive stream that a host delivers one byte at a time. The host fills a 16-byte staging buffer, then writes a bit count to start a transfer. The stager then moves that many bits, one per clock, into a serial deframer. The deframer looks for the opening and closing flags (0x7E), removes zeros inserted by the transmitter's bit stuffing, and packs the remaining payload bits into bytes. It pushes each byte into a 21-entry receive FIFO, which the host drains through the same address it uses to fill the buffer.

The raw stream is continuous across transfers. Frame state, partial bytes and bits in flight all carry over from one transfer into the next. After reset, and after an abort (seven or more ones in a row), the deframer discards every bit until it sees a flag. Each payload bit is held in a seven-bit delay line before it is committed, so no bit that belongs to a flag ever reaches the byte assembler.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A host write to the count address (0) with a nonzero value N, made while idle, starts a transfer. `busy` is high for exactly N cycles, and one raw bit moves to the deframer per cycle.
- R2: A count above 128 moves 128 bits. A count of 0 starts nothing: `busy` stays low and the FIFO is unchanged.
- R3: Host writes to the data address (1) fill the staging buffer at entries 0, 1, 2 and so on, and the fill position returns to 0 when a transfer starts. Raw bit number 8*i+b of a transfer is bit b of entry i, so the stream is sent LSB first.
- R4: A flag is a 0, then six 1s, then a 0 in the raw stream. Flag bits never enter the FIFO. Two flags may share one zero. Payload bits that do not make a whole byte before a flag are discarded.
- R5: Within a frame, a 0 that follows exactly five 1s is deleted from the payload.
- R6: Payload bits are packed LSB first. A byte is pushed only when all 8 of its bits have arrived.
- R7: After reset, and after seven consecutive 1s, no byte is pushed until a flag has been seen.
- R8: The FIFO holds 21 bytes and returns them oldest first. A read at the data address shows the oldest byte on `rd_data` from the next cycle on. `fifo_empty` and `fifo_full` report the fill state.
- R9: A byte pushed while the FIFO is full and no read happens in that cycle is dropped, and `fifo_overflow` is set. It stays set until reset. A push and a read in the same cycle while the FIFO is full both take effect, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write address: 0 bit count, 1 staging buffer |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Read address: 1 pops the receive FIFO |
| rd_data | output | 8 | Byte most recently popped |
| busy | output | 1 | A transfer is in progress |
| fifo_empty | output | 1 | Receive FIFO holds no bytes |
| fifo_full | output | 1 | Receive FIFO holds 21 bytes |
| fifo_overflow | output | 1 | Sticky: a byte was dropped because the FIFO was full |

## Verification
A byte can complete in the deframer in the same cycle that the host pops the FIFO while it is full. This is the collision that decides between dropping the byte and accepting it. The bench fills the FIFO to 21 entries, then starts a transfer holding one flag-bracketed byte. It counts clock edges from the count write and raises a read exactly on the edge where that byte's eighth payload bit leaves the delay line. The expected result is that `fifo_full` stays high, `fifo_overflow` stays low, and the drained contents end with the new byte. A second transfer then arrives with no read, and there the drop and the sticky flag are expected.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   // Raw-stream constants of the line code
   localparam int unsigned FLAG_LEN  = 8;            // 0 111111 0
   localparam int unsigned STUFF_RUN = 5;            // ones before a deleted zero
   localparam int unsigned FLAG_RUN  = 6;            // ones inside a flag
   localparam int unsigned RUN_W     = 3;            // run counter width
   localparam int unsigned HOLD_LEN  = FLAG_LEN - 1; // delay-line depth

   // Host address map
   localparam int unsigned ADDR_W     = 2;
   localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd1;

   typedef enum logic [0:0] {
      RX_HUNT  = 1'b0,
      RX_FRAME = 1'b1
   } rx_state_e;

endpackage

// File: rtl/hdlc_rx_stager.sv
module hdlc_rx_stager #(
   parameter int unsigned BUF_BYTES = 16,
   parameter int unsigned CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_we,
   input  logic [7:0]       buf_wdata,
   input  logic             start_we,
   input  logic [CNT_W-1:0] start_cnt,
   output logic             bit_valid,
   output logic             bit_data,
   output logic             busy
);

   localparam int unsigned MAX_BITS = BUF_BYTES * 8;
   localparam int unsigned IDX_W    = $clog2(BUF_BYTES);
   localparam int unsigned BIT_W    = $clog2(MAX_BITS);
   localparam int unsigned REM_W    = $clog2(MAX_BITS + 1);

   generate
      if ((1 << IDX_W) != BUF_BYTES) begin : g_bad_depth
         $error("hdlc_rx_stager: BUF_BYTES must be a power of two");
      end
      if (((1 << CNT_W) - 1) < MAX_BITS) begin : g_bad_cnt
         $error("hdlc_rx_stager: CNT_W too narrow for the buffer");
      end
   endgenerate

   logic [7:0]       mem [BUF_BYTES];
   logic [IDX_W-1:0] wr_ptr;
   logic [BIT_W-1:0] rd_pos;
   logic [REM_W-1:0] remain;
   logic [REM_W-1:0] req;
   logic             go;
   logic             fill;

   // Clamp the requested bit count to the buffer size
   always_comb begin
      if (32'(start_cnt) > MAX_BITS) req = REM_W'(MAX_BITS);
      else                           req = REM_W'(start_cnt);
   end

   assign busy      = (remain != '0);
   assign go        = start_we && !busy && (req != '0);
   assign fill      = buf_we && !busy && !go;
   assign bit_valid = busy;
   assign bit_data  = mem[rd_pos[BIT_W-1:3]][rd_pos[2:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         rd_pos <= '0;
         wr_ptr <= '0;
      end else if (go) begin
         remain <= req;
         rd_pos <= '0;
         wr_ptr <= '0;
      end else begin
         if (busy) begin
            remain <= remain - 1'b1;
            rd_pos <= rd_pos + 1'b1;
         end
         if (fill) wr_ptr <= wr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill) mem[wr_ptr] <= buf_wdata;
   end

   // R2: a zero count never raises busy
   a_r2_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_we && (start_cnt == '0) && !busy) |=> !busy);
   // R2: the bits left to send never exceed the buffer
   a_r2_remain_capped: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= REM_W'(MAX_BITS));
   // R1: the last bit ends the transfer
   a_r1_last_bit_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (remain == REM_W'(1)) && !start_we) |=> !busy);
   // R1: a valid start always raises busy
   a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_we && !busy && (start_cnt != '0)) |=> busy);

endmodule

// File: rtl/hdlc_rx_unstuffer.sv
module hdlc_rx_unstuffer
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_data,
   output logic              byte_push,
   output logic [BYTE_W-1:0] byte_data
);

   localparam int unsigned POS_W = $clog2(BYTE_W);

   generate
      if ((1 << POS_W) != BYTE_W) begin : g_bad_byte
         $error("hdlc_rx_unstuffer: BYTE_W must be a power of two");
      end
   endgenerate

   rx_state_e            state;
   logic [RUN_W-1:0]     ones;
   logic [HOLD_LEN-1:0]  hold_d;
   logic [HOLD_LEN-1:0]  hold_v;
   logic [BYTE_W-1:0]    acc;
   logic [POS_W-1:0]     pos;
   logic                 is_flag;
   logic                 is_abort;
   logic                 is_stuff;
   logic                 commit;
   logic                 out_bit;
   logic [RUN_W-1:0]     ones_nxt;

   assign out_bit  = hold_d[HOLD_LEN-1];
   assign is_flag  = bit_valid && !bit_data && (ones == RUN_W'(FLAG_RUN));
   assign is_abort = bit_valid && bit_data && (ones >= RUN_W'(FLAG_RUN));
   assign is_stuff = bit_valid && !bit_data && (ones == RUN_W'(STUFF_RUN));
   assign commit   = bit_valid && hold_v[HOLD_LEN-1] && !is_flag && !is_abort;

   assign byte_push = commit && (pos == POS_W'(BYTE_W - 1));
   assign byte_data = {out_bit, acc[BYTE_W-2:0]};

   always_comb begin
      if (!bit_data)                    ones_nxt = '0;
      else if (ones == {RUN_W{1'b1}})   ones_nxt = ones;
      else                              ones_nxt = ones + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RX_HUNT;
         ones   <= '0;
         hold_d <= '0;
         hold_v <= '0;
         acc    <= '0;
         pos    <= '0;
      end else if (bit_valid) begin
         ones   <= ones_nxt;
         hold_d <= {hold_d[HOLD_LEN-2:0], bit_data};
         if (is_flag || is_abort) begin
            hold_v <= '0;
            pos    <= '0;
            state  <= is_flag ? RX_FRAME : RX_HUNT;
         end else begin
            hold_v <= {hold_v[HOLD_LEN-2:0], (state == RX_FRAME) && !is_stuff};
            if (commit) begin
               acc[pos] <= out_bit;
               pos      <= pos + 1'b1;
            end
         end
      end
   end

   // R7: nothing leaves while hunting for a flag
   a_r7_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_HUNT) |-> !byte_push);
   // R7: a seventh one forces a hunt
   a_r7_abort_hunts: assert property (@(posedge clk) disable iff (!rst_n)
      is_abort |=> (state == RX_HUNT));
   // R4: a flag drops all bits in flight and any partial byte
   a_r4_flag_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      is_flag |=> ((hold_v == '0) && (pos == '0)));
   // R5: a deleted zero never becomes payload
   a_r5_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      is_stuff |=> !hold_v[0]);
   // R6: a push restarts byte assembly
   a_r6_push_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      byte_push |=> (pos == '0));

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
   parameter int unsigned DEPTH = 21,
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             empty,
   output logic             full,
   output logic             overflow
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = ((1 << PTR_W) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hdlc_rx_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             pop_ok, push_ok;

   // Pointer advance: natural wrap or explicit compare
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         pop_data <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok) begin
            rd_ptr   <= rd_nxt;
            pop_data <= mem[rd_ptr];
         end
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
         if (push && !push_ok) overflow <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   // R8: fill level stays in range and flags never coincide
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
   // R9: dropped push raises the sticky flag, which then holds
   a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> overflow);
   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R9: push with pop at full keeps the FIFO full without a drop
   a_r9_swap_at_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && full && !overflow) |=> (full && !overflow));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned BUF_BYTES  = 16,
   parameter int unsigned FIFO_DEPTH = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic              fifo_overflow
);

   localparam int unsigned BYTE_W = 8;

   logic              bit_valid;
   logic              bit_data;
   logic              byte_push;
   logic [BYTE_W-1:0] byte_data;
   logic              buf_we;
   logic              start_we;
   logic              pop;

   assign buf_we   = wr_en && (wr_addr == ADDR_DATA);
   assign start_we = wr_en && (wr_addr == ADDR_COUNT);
   assign pop      = rd_en && (rd_addr == ADDR_DATA);

   hdlc_rx_stager #(
      .BUF_BYTES (BUF_BYTES),
      .CNT_W     (BYTE_W)
   ) stager_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_we    (buf_we),
      .buf_wdata (wr_data),
      .start_we  (start_we),
      .start_cnt (wr_data),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .busy      (busy)
   );

   hdlc_rx_unstuffer #(
      .BYTE_W (BYTE_W)
   ) unstuff_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .byte_push (byte_push),
      .byte_data (byte_data)
   );

   hdlc_rx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (BYTE_W)
   ) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (byte_push),
      .push_data (byte_data),
      .pop       (pop),
      .pop_data  (rd_data),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .overflow  (fifo_overflow)
   );

   // R6: bytes enter the FIFO only while bits are moving
   a_r6_push_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
      byte_push |-> bit_valid);
   // R1: bits flow only while the block reports busy
   a_r1_bits_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> busy);

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       busy, fifo_empty, fifo_full, fifo_overflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   hdlc_rx_deframer dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .fifo_overflow(fifo_overflow)
   );

   // Stimulus table: raw buffer bytes, bit count, expected payload
   localparam int NV = 7;
   localparam logic [7:0] T_BUF [NV][6] = '{
      '{8'h7E, 8'h3C, 8'h7E, 8'h00, 8'h00, 8'h00},  // R4 R6 one byte
      '{8'h7E, 8'h12, 8'h34, 8'h56, 8'h7E, 8'h00},  // R8 order
      '{8'h7E, 8'hDF, 8'h01, 8'hFC, 8'h00, 8'h00},  // R5 FF,00 stuffed
      '{8'h7E, 8'hBE, 8'hFC, 8'h00, 8'h00, 8'h00},  // R5 payload 7E
      '{8'h7E, 8'hA5, 8'hE4, 8'h07, 8'h00, 8'h00},  // R4 partial dropped
      '{8'h7E, 8'hBF, 8'h40, 8'h3F, 8'h00, 8'h00},  // R4 shared zero
      '{8'h7E, 8'h7F, 8'h00, 8'h3F, 8'h21, 8'h3F}   // R7 abort, hunt
   };
   localparam int T_LEN  [NV] = '{3, 5, 5, 4, 4, 4, 6};
   localparam int T_BITS [NV] = '{24, 40, 33, 25, 28, 31, 47};
   localparam int T_NEXP [NV] = '{1, 3, 2, 1, 1, 1, 1};
   localparam int T_REQ  [NV] = '{6, 8, 5, 5, 4, 4, 7};
   localparam logic [7:0] T_EXP [NV][3] = '{
      '{8'h3C, 8'h00, 8'h00},
      '{8'h12, 8'h34, 8'h56},
      '{8'hFF, 8'h00, 8'h00},
      '{8'h7E, 8'h00, 8'h00},
      '{8'hA5, 8'h00, 8'h00},
      '{8'h81, 8'h00, 8'h00},
      '{8'h42, 8'h00, 8'h00}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 2'd1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic settle();
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   initial begin : main
      logic [7:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      check("R8 reset empty", fifo_empty, 1);
      check("R8 reset full", fifo_full, 0);
      check("R9 reset overflow", fifo_overflow, 0);
      check("R1 reset busy", busy, 0);

      // R7: bits before any flag are dropped
      wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd0, 8'd16);
      settle();
      check("R7 hunt after reset", fifo_empty, 1);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < T_LEN[v]; i++) wr(2'd1, T_BUF[v][i]);
         wr(2'd0, 8'(T_BITS[v]));
         settle();
         for (int e = 0; e < T_NEXP[v]; e++) begin
            rd(d);
            check($sformatf("R%0d vector %0d byte %0d", T_REQ[v], v, e), d, T_EXP[v][e]);
         end
         check($sformatf("R%0d vector %0d drained", T_REQ[v], v), fifo_empty, 1);
      end

      // R2: count zero starts nothing
      wr(2'd0, 8'd0);
      check("R2 zero count busy", busy, 0);
      repeat (5) @(negedge clk);
      check("R2 zero count fifo", fifo_empty, 1);

      // R2 R1: count 200 clamps to 128 cycles; 14 zero bytes framed
      wr(2'd1, 8'h7E);
      for (int i = 0; i < 14; i++) wr(2'd1, 8'h00);
      wr(2'd1, 8'h7E);
      wr(2'd0, 8'd200);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R2 clamp busy cycles", n, 128);
      repeat (10) @(negedge clk);
      check("R3 full buffer fifo not empty", fifo_empty, 0);

      // R8: 7 more bytes reach 21 entries
      wr(2'd1, 8'h7E);
      for (int i = 0; i < 7; i++) wr(2'd1, 8'h5A);
      wr(2'd1, 8'h7E);
      wr(2'd0, 8'd72);
      settle();
      check("R8 full at 21", fifo_full, 1);
      check("R9 no overflow at 21", fifo_overflow, 0);

      // R9: push and pop in one cycle while full
      wr(2'd1, 8'h7E); wr(2'd1, 8'hA5); wr(2'd1, 8'h7E);
      wr(2'd0, 8'd24);            // start edge E0 just passed
      repeat (22) @(negedge clk); // after E22
      rd_en = 1'b1; rd_addr = 2'd1;
      @(negedge clk);             // pop on E23, same edge as push
      rd_en = 1'b0;
      check("R9 collide popped oldest", rd_data, 8'h00);
      check("R9 collide still full", fifo_full, 1);
      check("R9 collide no overflow", fifo_overflow, 0);
      settle();
      check("R9 collide overflow later", fifo_overflow, 0);

      // R9: push while full with no read is dropped
      wr(2'd1, 8'h7E); wr(2'd1, 8'h33); wr(2'd1, 8'h7E);
      wr(2'd0, 8'd24);
      settle();
      check("R9 drop sets overflow", fifo_overflow, 1);
      check("R9 drop stays full", fifo_full, 1);

      // R8: drain and verify order, no 0x33
      for (int i = 0; i < 13; i++) begin
         rd(d); check($sformatf("R8 drain zero %0d", i), d, 8'h00);
      end
      for (int i = 0; i < 7; i++) begin
         rd(d); check($sformatf("R8 drain 5A %0d", i), d, 8'h5A);
      end
      rd(d); check("R9 collided byte kept", d, 8'hA5);
      check("R9 dropped byte absent", fifo_empty, 1);
      check("R9 overflow sticky", fifo_overflow, 1);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule